// File: doc/BRIEF.md
# Timer Host Bus Decoder with Readback Latching

This block is the host side of a three-channel timer. It watches an 8-bit host bus made of an active-low chip select, active-low read and write strobes and a two-bit address. From these it produces one-cycle write pulses for each counter and for the control register, and it drives read data for the counter that is addressed. Every other bus state is a no-operation that leaves the data bus undriven. The counters themselves live elsewhere. Each one presents its running count and its status byte to this block as plain input vectors.

The block also recognises the readback form of a control-register write. One such write can freeze the count, the status, or both, for any subset of the three counters. A frozen item keeps its value until the host has read it. A second request for an item that is already frozen is ignored, while any other item named in the same request is still frozen. When both items of a counter are frozen, the host reads the status byte first and then the count, low byte first. Each frozen item is released when its last byte has been read. A counter with nothing frozen returns its live count, low byte then high byte.

Top module: `tmr_bus_rb`

## Requirements
- R1: A write completes on the rising edge of `wr_n`, provided `cs_n` was low while `wr_n` was low. A completed write to address 0, 1 or 2 raises bit 0, 1 or 2 of `ctr_wr` for exactly one clock, starting with the first clock edge that sees `wr_n` high, and `wr_byte` carries the written byte during that pulse. The bits of `ctr_wr` and `ctl_wr` are never high together.
- R2: A completed write to address 3 that is not a readback command raises `ctl_wr` for one clock, with the same timing and with `wr_byte` valid.
- R3: With `cs_n` high, `rd_n` high, or a read at address 3, `dout_en` is low. A write made while `cs_n` is high produces no pulse.
- R4: `dout_en` is high exactly while `cs_n` and `rd_n` are both low and the address is 0, 1 or 2. While it is high, `dout` shows the addressed counter's next byte. A counter with no frozen item returns its live count, low byte first and then high byte, on successive reads.
- R5: A write to address 3 is a readback command when bits 7 and 6 are 1 and bit 0 is 0. Bits 1, 2 and 3 select counters 0, 1 and 2. Bit 5 at 0 requests a count freeze and bit 4 at 0 requests a status freeze. A readback command does not pulse `ctl_wr`. A write to address 3 with bit 0 set is an ordinary control write.
- R6: When status is frozen, the next read of that counter returns the frozen status byte, releases the status and leaves the count freeze as it was.
- R7: A frozen count is a snapshot that ignores later changes of the live count. It is read low byte then high byte, and it is released after the high byte is read.
- R8: A freeze request for an item that is already frozen is ignored and keeps the earlier snapshot. Other items named in the same command are still frozen.
- R9: After reset nothing is frozen, every counter's next byte is its low count byte, and all pulses and `dout_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus inputs are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address: 0 to 2 select a counter, 3 selects the control register |
| din | input | 8 | Host write data |
| dout | output | 8 | Read data, valid while `dout_en` is high |
| dout_en | output | 1 | Data bus drive enable; low means three-stated |
| live_cnt | input | 3*CW | Running counts, counter 0 in the low bits |
| live_st | input | 24 | Status bytes, counter 0 in the low byte |
| ctr_wr | output | 3 | One-cycle write pulse per counter |
| ctl_wr | output | 1 | One-cycle pulse for an ordinary control write |
| wr_byte | output | 8 | Byte of the completed write |

## Verification
The bench builds the block with its default 16-bit count width, so every count is read in two bytes. This puts within reach the ordering of the status byte ahead of the low and high count bytes, and release after the high byte. The live counts and status bytes are changed between freeze and read, so a snapshot that wrongly follows its input shows up as a mismatch. Readback words with overlapping counter selections and repeated requests exercise the ignore rule for each item on its own.

// File: rtl/tmr_rb_pkg.sv
package tmr_rb_pkg;
    localparam int AW       = 2;                 // address bits
    localparam int NCH      = (1 << AW) - 1;     // counters; last address is control
    localparam int BW       = 8;                 // host bus width
    localparam int RB_SEL0  = 1;                 // readback select bit for counter 0
    localparam int RB_NCNT  = 5;                 // active-low count freeze request
    localparam int RB_NST   = 4;                 // active-low status freeze request
endpackage

// File: rtl/tmr_rb_strobe.sv
// Captures bus cycles while a strobe is low; emits one event per completed cycle.
module tmr_rb_strobe
    import tmr_rb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] din,
    output logic          wr_evt,
    output logic [AW-1:0] wr_addr,
    output logic [BW-1:0] wr_data,
    output logic          rd_evt,
    output logic [AW-1:0] rd_addr
);
    typedef struct packed {
        logic          wr_prev;
        logic          rd_prev;
        logic          wsel;
        logic          rsel;
        logic [AW-1:0] waddr;
        logic [AW-1:0] raddr;
        logic [BW-1:0] wdata;
        logic          wr_evt;
        logic          rd_evt;
    } strobe_t;

    strobe_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_n;
        st_d.rd_prev = rd_n;
        if (!wr_n) begin
            st_d.wsel  = !cs_n;
            st_d.waddr = addr;
            st_d.wdata = din;
        end
        if (!rd_n) begin
            st_d.rsel  = !cs_n;
            st_d.raddr = addr;
        end
        // completion is the rising strobe edge of a selected cycle
        st_d.wr_evt = !st_q.wr_prev && wr_n && st_q.wsel;
        st_d.rd_evt = !st_q.rd_prev && rd_n && st_q.rsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.wr_prev <= 1'b1;
            st_q.rd_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_evt  = st_q.wr_evt;
    assign wr_addr = st_q.waddr;
    assign wr_data = st_q.wdata;
    assign rd_evt  = st_q.rd_evt;
    assign rd_addr = st_q.raddr;
endmodule

// File: rtl/tmr_rb_chan.sv
// Freeze state and read sequencing of one counter.
module tmr_rb_chan
    import tmr_rb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rb_go,
    input  logic          want_cnt,
    input  logic          want_st,
    input  logic          rd_go,
    input  logic [CW-1:0] live_cnt,
    input  logic [BW-1:0] live_st,
    output logic [BW-1:0] rd_byte,
    output logic          cnt_held,
    output logic          st_held
);
    localparam int NB = CW / BW;
    localparam int PW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic          cnt_held;
        logic          st_held;
        logic [PW-1:0] ptr;
        logic [CW-1:0] cnt_snap;
        logic [BW-1:0] st_snap;
    } chan_t;

    chan_t ch_d, ch_q;
    logic [CW-1:0] src;

    always_comb begin
        ch_d = ch_q;
        if (rd_go) begin
            if (ch_q.st_held) begin
                ch_d.st_held = 1'b0;             // status is served first (R6)
            end else if (ch_q.ptr == PW'(NB - 1)) begin
                ch_d.ptr      = '0;
                ch_d.cnt_held = 1'b0;            // released after last byte (R7)
            end else begin
                ch_d.ptr = ch_q.ptr + 1'b1;
            end
        end
        if (rb_go) begin
            if (want_cnt && !ch_q.cnt_held) begin // repeat ignored (R8)
                ch_d.cnt_held = 1'b1;
                ch_d.cnt_snap = live_cnt;
                ch_d.ptr      = '0;
            end
            if (want_st && !ch_q.st_held) begin
                ch_d.st_held = 1'b1;
                ch_d.st_snap = live_st;
            end
        end
    end

    always_comb begin
        src     = ch_q.cnt_held ? ch_q.cnt_snap : live_cnt;
        rd_byte = ch_q.st_snap;
        if (!ch_q.st_held) begin
            rd_byte = '0;
            for (int b = 0; b < NB; b++) begin
                if (ch_q.ptr == PW'(b)) rd_byte = src[BW*b +: BW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign cnt_held = ch_q.cnt_held;
    assign st_held  = ch_q.st_held;
endmodule

// File: rtl/tmr_bus_rb.sv
module tmr_bus_rb
    import tmr_rb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [AW-1:0]     addr,
    input  logic [BW-1:0]     din,
    output logic [BW-1:0]     dout,
    output logic              dout_en,
    input  logic [NCH*CW-1:0] live_cnt,
    input  logic [NCH*BW-1:0] live_st,
    output logic [NCH-1:0]    ctr_wr,
    output logic              ctl_wr,
    output logic [BW-1:0]     wr_byte
);
    logic          wr_evt, rd_evt;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [BW-1:0] wr_data;
    logic          is_rb, ctl_evt;
    logic [NCH-1:0] rb_go_w, rd_go_w, cnt_held_w, st_held_w;
    logic [BW-1:0]  chan_byte [NCH];

    tmr_rb_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din),
        .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_evt(rd_evt), .rd_addr(rd_addr)
    );

    assign ctl_evt = wr_evt && (wr_addr == AW'(NCH));
    assign is_rb   = (wr_data[7:6] == 2'b11) && !wr_data[0];
    assign ctl_wr  = ctl_evt && !is_rb;
    assign wr_byte = wr_data;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign ctr_wr[i]  = wr_evt && (wr_addr == AW'(i));
        assign rb_go_w[i] = ctl_evt && is_rb && wr_data[RB_SEL0 + i];
        assign rd_go_w[i] = rd_evt && (rd_addr == AW'(i));

        tmr_rb_chan #(.CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .rb_go(rb_go_w[i]),
            .want_cnt(!wr_data[RB_NCNT]),
            .want_st(!wr_data[RB_NST]),
            .rd_go(rd_go_w[i]),
            .live_cnt(live_cnt[CW*i +: CW]),
            .live_st(live_st[BW*i +: BW]),
            .rd_byte(chan_byte[i]),
            .cnt_held(cnt_held_w[i]),
            .st_held(st_held_w[i])
        );
    end

    always_comb begin
        dout_en = !cs_n && !rd_n && (addr != AW'(NCH));
        dout    = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == AW'(i)) dout = chan_byte[i];
        end
    end
endmodule

// File: rtl/tmr_bus_rb_chk.sv
module tmr_bus_rb_chk
    import tmr_rb_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n,
    input logic           dout_en,
    input logic [NCH-1:0] ctr_wr,
    input logic           ctl_wr,
    input logic [NCH-1:0] rb_go,
    input logic [NCH-1:0] rd_go,
    input logic [NCH-1:0] cnt_held,
    input logic [NCH-1:0] st_held
);
    assert_wr_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctr_wr, ctl_wr}));

    assert_wr_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctr_wr) |=> (ctr_wr == '0));

    assert_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dout_en);

    assert_rb_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|rb_go) |-> !ctl_wr);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assert_st_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (st_held[i] && !rd_go[i]) |=> st_held[i]);

        assert_cnt_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_held[i] && !rd_go[i]) |=> cnt_held[i]);

        assert_st_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_go[i] && st_held[i] && cnt_held[i]) |=> cnt_held[i]);
    end
endmodule

bind tmr_bus_rb tmr_bus_rb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout_en(dout_en),
    .ctr_wr(ctr_wr), .ctl_wr(ctl_wr),
    .rb_go(rb_go_w), .rd_go(rd_go_w),
    .cnt_held(cnt_held_w), .st_held(st_held_w)
);

// File: tb/tb_tmr_bus_rb.sv
module tb_tmr_bus_rb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  din = 8'd0;
    logic [7:0]  dout, wr_byte;
    logic        dout_en, ctl_wr;
    logic [2:0]  ctr_wr;
    logic [15:0] lc [3];
    logic [7:0]  ls [3];
    logic [47:0] live_cnt;
    logic [23:0] live_st;

    // behavioural reference state
    bit          m_cl [3];
    bit          m_sl [3];
    bit          m_hi [3];
    logic [15:0] m_cs [3];
    logic [7:0]  m_ss [3];
    logic [2:0]  exp_ctr = '0;
    logic        exp_ctl = 1'b0;
    logic [7:0]  exp_dout = '0;
    logic [7:0]  got;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    assign live_cnt = {lc[2], lc[1], lc[0]};
    assign live_st  = {ls[2], ls[1], ls[0]};

    always #4 clk = ~clk;

    tmr_bus_rb dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .live_cnt(live_cnt), .live_st(live_st),
        .ctr_wr(ctr_wr), .ctl_wr(ctl_wr), .wr_byte(wr_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] item(input int i);
        logic [15:0] src;
        if (m_sl[i]) return m_ss[i];
        src = m_cl[i] ? m_cs[i] : lc[i];
        return m_hi[i] ? src[15:8] : src[7:0];
    endfunction

    // per-clock comparison against the reference
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R3/R4 dout_en", dout_en, !cs_n && !rd_n && addr != 2'd3);
            if (dout_en) chk("R4 dout", dout, exp_dout);
            chk("R1 ctr_wr", ctr_wr, exp_ctr);
            chk("R2 ctl_wr", ctl_wr, exp_ctl);
            if (exp_ctr != 0 || exp_ctl) chk("R1 wr_byte", wr_byte, din);
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit sel);
        bit rb;
        rb = (d[7:6] == 2'b11) && !d[0];
        @(negedge clk); cs_n = !sel; addr = a; din = d; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        @(posedge clk); #1;
        if (sel) begin
            if (a < 2'd3) exp_ctr = 3'(1 << a);
            else if (!rb) exp_ctl = 1'b1;
        end
        @(posedge clk); #1;
        exp_ctr = '0; exp_ctl = 1'b0;
        if (sel && a == 2'd3 && rb) begin
            for (int i = 0; i < 3; i++) begin
                if (d[i+1]) begin
                    if (!d[5] && !m_cl[i]) begin m_cl[i] = 1; m_cs[i] = lc[i]; m_hi[i] = 0; end
                    if (!d[4] && !m_sl[i]) begin m_sl[i] = 1; m_ss[i] = ls[i]; end
                end
            end
        end
        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [1:0] a, input bit sel, input string req,
                          output logic [7:0] val);
        if (a < 2'd3) exp_dout = item(a);
        @(negedge clk); cs_n = !sel; addr = a; rd_n = 1'b0;
        @(posedge clk); #3;
        val = dout;
        if (sel && a < 2'd3) chk(req, {dout_en, dout}, {1'b1, exp_dout});
        else                 chk(req, dout_en, 1'b0);
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        if (sel && a < 2'd3) begin
            if (m_sl[a]) m_sl[a] = 0;
            else begin
                if (m_hi[a] && m_cl[a]) m_cl[a] = 0;
                m_hi[a] = !m_hi[a];
            end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        lc[0] = 16'h1234; lc[1] = 16'h5678; lc[2] = 16'h9abc;
        ls[0] = 8'h11;    ls[1] = 8'h22;    ls[2] = 8'h33;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #3;
        chk("R9 idle outputs", {ctr_wr, ctl_wr, dout_en}, 0);
        bus_rd(2'd0, 1, "R9 first byte is low", got);
        bus_rd(2'd0, 1, "R4 live high byte", got);
        bus_rd(2'd2, 1, "R4 live low byte ctr2", got);
        bus_rd(2'd2, 1, "R4 live high byte ctr2", got);
        // R1 counter writes, R2 control write, R3 deselected write
        bus_wr(2'd0, 8'h5a, 1);
        bus_wr(2'd1, 8'ha5, 1);
        bus_wr(2'd2, 8'h3c, 1);
        bus_wr(2'd3, 8'h34, 1);
        bus_wr(2'd1, 8'h77, 0);
        bus_rd(2'd3, 1, "R3 read at control address", got);
        bus_rd(2'd1, 0, "R3 deselected read", got);
        // R5/R8 status-only freeze of counters 2 and 1, then repeat for 1
        bus_wr(2'd3, 8'hec, 1);
        ls[1] = 8'h44; ls[2] = 8'h55;
        bus_wr(2'd3, 8'he4, 1);
        bus_rd(2'd1, 1, "R8 old status kept ctr1", got);
        chk("R8 snapshot value", got, 8'h22);
        bus_rd(2'd2, 1, "R6 status ctr2", got);
        bus_rd(2'd2, 1, "R6 then live count ctr2", got);
        bus_rd(2'd2, 1, "R4 live high ctr2", got);
        // R7/R8 status frozen, then count+status request: only count added
        bus_wr(2'd3, 8'he4, 1);
        ls[1] = 8'h66;
        bus_wr(2'd3, 8'hc4, 1);
        lc[1] = 16'hdead; ls[1] = 8'h99;
        bus_rd(2'd1, 1, "R8 status first, earlier snapshot", got);
        chk("R8 status value", got, 8'h44);
        lc[1] = 16'hbeef;
        bus_rd(2'd1, 1, "R7 frozen low byte", got);
        chk("R7 frozen low value", got, 8'h78);
        bus_rd(2'd1, 1, "R7 frozen high byte", got);
        chk("R7 frozen high value", got, 8'h56);
        bus_rd(2'd1, 1, "R7 released to live", got);
        chk("R7 live after release", got, 8'hef);
        bus_rd(2'd1, 1, "R4 live high ctr1", got);
        // R8 repeated count freeze on counter 0
        bus_wr(2'd3, 8'hd2, 1);
        lc[0] = 16'h4321;
        bus_wr(2'd3, 8'hd2, 1);
        bus_rd(2'd0, 1, "R8 count low kept", got);
        bus_rd(2'd0, 1, "R8 count high kept", got);
        chk("R8 count value", got, 8'h12);
        // R5 bit 0 set: ordinary control write, no freeze
        bus_wr(2'd3, 8'hcf, 1);
        lc[0] = 16'h0f0f;
        bus_rd(2'd0, 1, "R5 no freeze with bit0 set", got);
        chk("R5 live value", got, 8'h0f);
        bus_rd(2'd0, 1, "R4 live high ctr0", got);
        // R5 all counters count+status in one command
        bus_wr(2'd3, 8'hce, 1);
        for (int i = 0; i < 3; i++) begin
            lc[i] = 16'h0; ls[i] = 8'h0;
        end
        for (int i = 0; i < 3; i++) begin
            bus_rd(2'(i), 1, "R5 multi status", got);
            bus_rd(2'(i), 1, "R5 multi count low", got);
            bus_rd(2'(i), 1, "R5 multi count high", got);
        end
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule